// File: doc/BRIEF.md
# Host Channel Interrupt Aggregator

This block collects interrupt events for a multi-channel USB host controller and folds them into one level interrupt line in two stages. Every channel owns a sticky status register, set by single-cycle event strobes, and a per-bit enable register aligned with it. A channel's pending bit is derived from its enabled status bits. A second enable register, one bit per channel, selects which pending channels raise the core channel interrupt bit. A separate group of sticky port change bits raises the core port interrupt bit. Each channel also holds a buffer address register that keeps only word-aligned values.

Software services an interrupt in two steps. It reads the pending register to find the channel, then writes ones to that channel's status bits. The pending bit and the core channel bit fall on their own once no enabled status bit is left. None of the derived bits can be written. Register reads come from a combinational port addressed apart from the write port. Writes take effect at the rising clock edge.

Top module: `hcia_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: An event strobe on bit b of channel c sets bit b of that channel's status register (address 0x40 + 4*c). The bit stays set until software clears it. This holds for the last implemented channel too.
- R3: Writing a 1 to a channel status bit clears it, and writing 0 leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: The pending register (0x02, read-only, bit c for channel c) shows the OR of status AND enable for each channel. The per-channel enable sits at 0x41 + 4*c. Writes to 0x02 have no effect.
- R5: Bit 0 of the core status register (0x00, read-only) is the OR of pending AND the channel-select register (0x03). Clearing a channel's status bits drops its pending bit and core bit 0 with no further write.
- R6: Port change bits (0x04) are set by port event strobes and cleared by writing 1, with set winning over clear. Core status bit 1 is high while any of them is set.
- R7: `irq_o` = ctl[2] AND ((core bit 0 AND ctl[0]) OR (core bit 1 AND ctl[1])), where ctl is the read/write control register at 0x01.
- R8: The buffer address register (0x42 + 4*c) stores write data with bits 1:0 forced to zero.
- R9: Addresses of unimplemented channels (c >= NUM_CH) and unassigned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_evt_i | input | NUM_CH*EVT_W | Channel event strobes, channel c at bits [c*EVT_W +: EVT_W] |
| port_evt_i | input | PORT_W | Port change event strobes |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | DATA_W | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker watches the port change bits on every cycle. It confirms that an event always leaves its bit set, that a clearing write removes only bits with no event that cycle, and that untouched bits hold. On every cycle it also checks that the interrupt line stays low without the global enable or a core source, that the core channel bit only falls after a write, and that channel 0's address register keeps only aligned values. The scenarios show the rest: the two-level collapse of the pending and core bits after a single leaf clear, read-only pending bits, and the channel-select gating. They also cover the set-wins race on channel status and the inert address space beyond the implemented channels.

// File: rtl/hcia_pkg.sv
package hcia_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CORE_STAT = 8'h00;
    localparam logic [ADDR_W-1:0] A_CORE_CTL  = 8'h01;
    localparam logic [ADDR_W-1:0] A_PENDING   = 8'h02;
    localparam logic [ADDR_W-1:0] A_CH_SELECT = 8'h03;
    localparam logic [ADDR_W-1:0] A_PORT_CHG  = 8'h04;
    localparam logic [1:0]        CH_PAGE     = 2'b01;

    localparam int CTL_W       = 3;
    localparam int CTL_CH_EN   = 0;
    localparam int CTL_PORT_EN = 1;
    localparam int CTL_GLB_EN  = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CORE_STAT,
        SEL_CORE_CTL,
        SEL_PENDING,
        SEL_CH_SELECT,
        SEL_PORT_CHG,
        SEL_CH_STAT,
        SEL_CH_EN,
        SEL_CH_ADDR
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a, input int num_ch);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[7:6] == CH_PAGE) begin
            if (int'(a[5:2]) < num_ch) begin
                unique case (a[1:0])
                    2'd0:    s = SEL_CH_STAT;
                    2'd1:    s = SEL_CH_EN;
                    2'd2:    s = SEL_CH_ADDR;
                    default: s = SEL_NONE;
                endcase
            end
        end else begin
            unique case (a)
                A_CORE_STAT: s = SEL_CORE_STAT;
                A_CORE_CTL:  s = SEL_CORE_CTL;
                A_PENDING:   s = SEL_PENDING;
                A_CH_SELECT: s = SEL_CH_SELECT;
                A_PORT_CHG:  s = SEL_PORT_CHG;
                default:     s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/hcia_chan.sv
module hcia_chan #(
    parameter int EVT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              stat_we_i,
    input  logic              en_we_i,
    input  logic              addr_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [EVT_W-1:0]  stat_o,
    output logic [EVT_W-1:0]  en_o,
    output logic [DATA_W-1:0] addr_o
);
    localparam int ALIGN_BITS = 2;

    logic [EVT_W-1:0]  stat_q;
    logic [EVT_W-1:0]  en_q;
    logic [DATA_W-1:0] addr_q;
    logic [EVT_W-1:0]  clr_mask;

    // write-one-to-clear, event set takes priority
    always_comb begin
        clr_mask = stat_we_i ? wdata_i[EVT_W-1:0] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
            en_q   <= '0;
            addr_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt_i;
            if (en_we_i) begin
                en_q <= wdata_i[EVT_W-1:0];
            end
            if (addr_we_i) begin
                addr_q <= {wdata_i[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            end
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign addr_o = addr_q;
endmodule

// File: rtl/hcia_port.sv
module hcia_port #(
    parameter int PORT_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] evt_i,
    input  logic              clr_we_i,
    input  logic [PORT_W-1:0] clr_data_i,
    output logic [PORT_W-1:0] chg_o
);
    logic [PORT_W-1:0] chg_q;
    logic [PORT_W-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_we_i ? clr_data_i : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chg_q <= '0;
        end else begin
            chg_q <= (chg_q & ~clr_mask) | evt_i;
        end
    end

    assign chg_o = chg_q;
endmodule

// File: rtl/hcia_tree.sv
module hcia_tree
    import hcia_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int EVT_W  = 8,
    parameter int PORT_W = 4
) (
    input  logic [NUM_CH-1:0][EVT_W-1:0] stat_i,
    input  logic [NUM_CH-1:0][EVT_W-1:0] en_i,
    input  logic [NUM_CH-1:0]            ch_sel_i,
    input  logic [PORT_W-1:0]            port_chg_i,
    input  logic [CTL_W-1:0]             ctl_i,
    output logic [NUM_CH-1:0]            pending_o,
    output logic                         core_ch_o,
    output logic                         core_port_o,
    output logic                         irq_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_leaf
        assign pending_o[c] = |(stat_i[c] & en_i[c]);
    end

    assign core_ch_o   = |(pending_o & ch_sel_i);
    assign core_port_o = |port_chg_i;

    assign irq_o = ctl_i[CTL_GLB_EN] &
                   ((core_ch_o & ctl_i[CTL_CH_EN]) | (core_port_o & ctl_i[CTL_PORT_EN]));
endmodule

// File: rtl/hcia_top.sv
module hcia_top
    import hcia_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int EVT_W  = 8,
    parameter int PORT_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_CH*EVT_W-1:0] ch_evt_i,
    input  logic [PORT_W-1:0]       port_evt_i,
    input  logic                    wr_en_i,
    input  logic [7:0]              wr_addr_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    input  logic [7:0]              rd_addr_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    irq_o
);
    reg_sel_e                     wr_sel;
    reg_sel_e                     rd_sel;
    logic [3:0]                   wr_ch;
    logic [3:0]                   rd_ch;

    logic [CTL_W-1:0]             ctl_q;
    logic [NUM_CH-1:0]            ch_sel_q;
    logic [NUM_CH-1:0][EVT_W-1:0] ch_stat;
    logic [NUM_CH-1:0][EVT_W-1:0] ch_en;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_addr;
    logic [PORT_W-1:0]            port_chg_q;
    logic [NUM_CH-1:0]            pending;
    logic                         core_ch_bit;
    logic                         core_port_bit;

    always_comb begin
        wr_sel = decode_addr(wr_addr_i, NUM_CH);
        rd_sel = decode_addr(rd_addr_i, NUM_CH);
        wr_ch  = wr_addr_i[5:2];
        rd_ch  = rd_addr_i[5:2];
    end

    // control and channel-select registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            ch_sel_q <= '0;
        end else if (wr_en_i) begin
            unique case (wr_sel)
                SEL_CORE_CTL:  ctl_q    <= wr_data_i[CTL_W-1:0];
                SEL_CH_SELECT: ch_sel_q <= wr_data_i[NUM_CH-1:0];
                default:       ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en_i && (wr_ch == 4'(c));
        hcia_chan #(
            .EVT_W  (EVT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (ch_evt_i[c*EVT_W +: EVT_W]),
            .stat_we_i (hit && (wr_sel == SEL_CH_STAT)),
            .en_we_i   (hit && (wr_sel == SEL_CH_EN)),
            .addr_we_i (hit && (wr_sel == SEL_CH_ADDR)),
            .wdata_i   (wr_data_i),
            .stat_o    (ch_stat[c]),
            .en_o      (ch_en[c]),
            .addr_o    (ch_addr[c])
        );
    end

    hcia_port #(
        .PORT_W (PORT_W)
    ) u_port (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (port_evt_i),
        .clr_we_i   (wr_en_i && (wr_sel == SEL_PORT_CHG)),
        .clr_data_i (wr_data_i[PORT_W-1:0]),
        .chg_o      (port_chg_q)
    );

    hcia_tree #(
        .NUM_CH (NUM_CH),
        .EVT_W  (EVT_W),
        .PORT_W (PORT_W)
    ) u_tree (
        .stat_i      (ch_stat),
        .en_i        (ch_en),
        .ch_sel_i    (ch_sel_q),
        .port_chg_i  (port_chg_q),
        .ctl_i       (ctl_q),
        .pending_o   (pending),
        .core_ch_o   (core_ch_bit),
        .core_port_o (core_port_bit),
        .irq_o       (irq_o)
    );

    // read multiplexer
    always_comb begin
        rd_data_o = '0;
        unique case (rd_sel)
            SEL_CORE_STAT: rd_data_o = DATA_W'({core_port_bit, core_ch_bit});
            SEL_CORE_CTL:  rd_data_o = DATA_W'(ctl_q);
            SEL_PENDING:   rd_data_o = DATA_W'(pending);
            SEL_CH_SELECT: rd_data_o = DATA_W'(ch_sel_q);
            SEL_PORT_CHG:  rd_data_o = DATA_W'(port_chg_q);
            SEL_CH_STAT, SEL_CH_EN, SEL_CH_ADDR: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (rd_ch == 4'(c)) begin
                        if (rd_sel == SEL_CH_STAT)    rd_data_o = DATA_W'(ch_stat[c]);
                        else if (rd_sel == SEL_CH_EN) rd_data_o = DATA_W'(ch_en[c]);
                        else                          rd_data_o = ch_addr[c];
                    end
                end
            end
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/hcia_chk.sv
module hcia_chk
    import hcia_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [7:0]        wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [PORT_W-1:0] port_evt_i,
    input logic [PORT_W-1:0] port_chg_q,
    input logic              core_ch_bit,
    input logic              core_port_bit,
    input logic [CTL_W-1:0]  ctl_q,
    input logic [DATA_W-1:0] addr0_q,
    input logic              irq_o
);
    logic port_wr;
    assign port_wr = wr_en_i && (wr_addr_i == A_PORT_CHG);

    for (genvar k = 0; k < PORT_W; k++) begin : g_bit
        AST_PORT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            port_evt_i[k] |=> port_chg_q[k]); // R6
        AST_PORT_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (port_wr && wr_data_i[k] && !port_evt_i[k]) |=> !port_chg_q[k]); // R6
        AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (port_chg_q[k] && !(port_wr && wr_data_i[k])) |=> port_chg_q[k]); // R6
    end

    AST_CH_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(core_ch_bit) |-> $past(wr_en_i)); // R5
    AST_IRQ_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_q[CTL_GLB_EN] |-> !irq_o); // R7
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (core_ch_bit || core_port_bit)); // R7
    AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 8'h42) |=> addr0_q == {$past(wr_data_i[DATA_W-1:2]), 2'b00}); // R8
endmodule

bind hcia_top hcia_chk #(
    .PORT_W (PORT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .port_evt_i    (port_evt_i),
    .port_chg_q    (port_chg_q),
    .core_ch_bit   (core_ch_bit),
    .core_port_bit (core_port_bit),
    .ctl_q         (ctl_q),
    .addr0_q       (ch_addr[0]),
    .irq_o         (irq_o)
);

// File: tb/sim_hcia_top.sv
module sim_hcia_top;
    localparam int NUM_CH = 8;
    localparam int EVT_W  = 8;
    localparam int PORT_W = 4;
    localparam int DATA_W = 32;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH*EVT_W-1:0] ch_evt = '0;
    logic [PORT_W-1:0]       port_evt = '0;
    logic                    wr_en = 1'b0;
    logic [7:0]              wr_addr = '0;
    logic [DATA_W-1:0]       wr_data = '0;
    logic [7:0]              rd_addr = '0;
    logic [DATA_W-1:0]       rd_data;
    logic                    irq;

    item_t q[$];
    bit    busy = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    hcia_top #(
        .NUM_CH (NUM_CH),
        .EVT_W  (EVT_W),
        .PORT_W (PORT_W),
        .DATA_W (DATA_W)
    ) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ch_evt_i   (ch_evt),
        .port_evt_i (port_evt),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .irq_o      (irq)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                busy = 1'b1;
                it = q.pop_front();
                rd_addr = it.addr;
                #1;
                act = it.is_irq ? {31'd0, irq} : rd_data;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: addr %h actual %h expected %h", it.tag, it.addr, act, it.exp);
                end
                busy = 1'b0;
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0 && !busy);
        @(negedge clk);
    endtask

    task automatic expect_irq(input bit e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0 && !busy);
        @(negedge clk);
    endtask

    // write with optional same-cycle events
    task automatic drive(input bit we, input logic [7:0] a, input logic [31:0] d,
                         input int ch, input logic [EVT_W-1:0] cev, input logic [PORT_W-1:0] pev);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        ch_evt = '0;
        if (ch >= 0) ch_evt[ch*EVT_W +: EVT_W] = cev;
        port_evt = pev;
        @(negedge clk);
        wr_en = 1'b0; ch_evt = '0; port_evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, -1, '0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        expect_rd(8'h00, 32'h0, "R1 core status after reset");
        expect_irq(1'b0, "R1 irq after reset");
        expect_rd(8'h40, 32'h0, "R1 ch0 status after reset");
        expect_rd(8'h03, 32'h0, "R1 channel select after reset");

        drive(1'b0, 8'h00, 32'h0, 2, 8'h05, '0);
        expect_rd(8'h48, 32'h05, "R2 ch2 status set by events");
        expect_rd(8'h02, 32'h00, "R4 pending low with enable clear");
        wr(8'h49, 32'h04);
        expect_rd(8'h02, 32'h04, "R4 pending follows enabled status");
        expect_rd(8'h00, 32'h00, "R5 core bit gated by channel select");
        wr(8'h02, 32'hFF);
        expect_rd(8'h02, 32'h04, "R4 pending ignores writes");
        wr(8'h03, 32'h04);
        expect_rd(8'h00, 32'h01, "R5 core channel bit set");
        expect_irq(1'b0, "R7 irq off without global enable");
        wr(8'h01, 32'h5);
        expect_irq(1'b1, "R7 irq with channel source enabled");
        wr(8'h01, 32'h4);
        expect_irq(1'b0, "R7 irq off with channel source disabled");
        wr(8'h01, 32'h5);

        wr(8'h48, 32'h00);
        expect_rd(8'h48, 32'h05, "R3 writing zero keeps status");
        wr(8'h48, 32'h04);
        expect_rd(8'h48, 32'h01, "R3 write one clears bit");
        expect_rd(8'h02, 32'h00, "R5 pending collapses after leaf clear");
        expect_rd(8'h00, 32'h00, "R5 core bit collapses after leaf clear");
        expect_irq(1'b0, "R5 irq drops after leaf clear");
        drive(1'b1, 8'h48, 32'h01, 2, 8'h01, '0);
        expect_rd(8'h48, 32'h01, "R3 set wins over same-cycle clear");
        wr(8'h48, 32'h01);
        expect_rd(8'h48, 32'h00, "R3 clear after race");

        drive(1'b0, 8'h00, 32'h0, 7, 8'h80, '0);
        expect_rd(8'h5C, 32'h80, "R2 last channel top bit");
        repeat (3) @(negedge clk);
        expect_rd(8'h5C, 32'h80, "R2 status stays set");

        drive(1'b0, 8'h00, 32'h0, 0, 8'h10, '0);
        wr(8'h41, 32'h10);
        expect_rd(8'h00, 32'h00, "R5 channel 0 not selected");
        wr(8'h03, 32'h05);
        expect_rd(8'h00, 32'h01, "R5 channel 0 selected");
        wr(8'h40, 32'h10);
        expect_rd(8'h00, 32'h00, "R5 collapse on channel 0");

        drive(1'b0, 8'h00, 32'h0, -1, '0, 4'h3);
        expect_rd(8'h04, 32'h3, "R6 port changes set");
        expect_rd(8'h00, 32'h2, "R6 core port bit");
        expect_irq(1'b0, "R7 port source disabled");
        wr(8'h01, 32'h6);
        expect_irq(1'b1, "R7 port source enabled");
        wr(8'h04, 32'h0);
        expect_rd(8'h04, 32'h3, "R6 writing zero keeps change");
        wr(8'h04, 32'h1);
        expect_rd(8'h04, 32'h2, "R6 write one clears change");
        drive(1'b1, 8'h04, 32'h2, -1, '0, 4'h2);
        expect_rd(8'h04, 32'h2, "R6 set wins over clear");
        wr(8'h04, 32'h2);
        expect_rd(8'h04, 32'h0, "R6 last change cleared");
        expect_rd(8'h00, 32'h0, "R6 core port bit cleared");
        expect_irq(1'b0, "R7 irq low with no source");

        wr(8'h4E, 32'h12345677);
        expect_rd(8'h4E, 32'h12345674, "R8 ch3 address aligned");
        wr(8'h42, 32'hFFFFFFFF);
        expect_rd(8'h42, 32'hFFFFFFFC, "R8 ch0 address aligned");

        wr(8'h70, 32'hFF);
        wr(8'h71, 32'hFF);
        wr(8'h72, 32'hFFFFFFFF);
        expect_rd(8'h70, 32'h0, "R9 unimplemented status");
        expect_rd(8'h71, 32'h0, "R9 unimplemented enable");
        expect_rd(8'h72, 32'h0, "R9 unimplemented address");
        wr(8'h05, 32'hFFFF);
        expect_rd(8'h05, 32'h0, "R9 unassigned address");
        expect_rd(8'h4E, 32'h12345674, "R9 implemented channel untouched");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule